// File: doc/BRIEF.md
# Branch prediction buffer

This block is a direct-mapped table that sits beside the instruction fetch stage. Each fetch address is looked up in the table while the instruction is fetched. After two clock edges the block reports whether the address hit a stored branch, the predicted direction, and the stored destination. A hit that predicts taken lets fetch jump to that destination at once. A miss gives no prediction, so fetch carries on sequentially.

Later pipeline stages report each resolved instruction on an update port. The report carries the instruction address, the taken outcome, the actual destination and a flag that marks it as a branch. Reports for other instructions are dropped, so only branches ever occupy entries.

Each entry holds a valid bit, an address tag, a word-aligned destination and a direction counter. By default the counter is a 2-bit saturating counter with hysteresis. A parameter can switch it to a single bit that remembers only the last outcome, which is useful for comparing the two schemes. After reset, a sweep clears every entry, and the table takes part in lookups and updates only once the sweep has finished.

Top module: `branch_pred_buf`

## Requirements
- R1: A lookup with `fetch_valid` high in cycle t produces `pred_valid` high in cycle t+2. In every cycle that answers no lookup, `pred_valid` is low.
- R2: The entry index is `pc[IDX_W+1:2]` and the tag is `pc[ADDR_W-1:IDX_W+2]`, where IDX_W is log2 of ENTRIES (12 by default). Address bits 1:0 play no part. A lookup whose tag differs from the stored tag of a valid entry misses.
- R3: A lookup that misses returns `pred_hit`=0, `pred_taken`=0 and `pred_target`=0.
- R4: An update with `upd_is_branch`=0 writes nothing, so a later lookup of that address still misses.
- R5: A branch update that misses, either because the entry is invalid or because the tag differs, replaces the entry. The new entry holds the new tag and destination, and its counter is set to 2 (weakly taken) when the branch was taken or to 1 (weakly not taken) when it was not.
- R6: In the 2-bit mode, a branch update that hits adds 1 to the counter on taken and subtracts 1 on not taken, saturating at 3 and at 0. The predicted direction is counter bit 1.
- R7: A branch update that hits replaces the stored destination only when the branch was taken. Destination bits 1:0 are stored and returned as zero.
- R8: A lookup that hits returns `pred_hit`=1, the stored destination on `pred_target`, and the predicted direction on `pred_taken`.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup sees the contents from before that update. Updates to one entry in consecutive cycles each build on the result of the previous one.
- R10: With PRED_BITS=1, the predicted direction of a valid entry is the outcome of the most recent update to it.
- R11: Reset is synchronous and active high, and it holds all outputs at 0. After reset is released, the table is cleared over ENTRIES cycles. Lookups in that window miss, and updates in that window are dropped. After the window, every address misses.
- R12: Consider a loop branch taken n-1 times and then not taken, executed twice. On the second pass the 2-bit mode predicts n-1 of the n outcomes correctly, while the 1-bit mode predicts n-2 correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is presented this cycle |
| fetch_pc | input | ADDR_W | Fetch address to look up |
| pred_valid | output | 1 | Lookup answer is present (two cycles after the lookup) |
| pred_hit | output | 1 | The looked-up address is a known branch |
| pred_taken | output | 1 | Hit and predicted taken: redirect fetch |
| pred_target | output | ADDR_W | Stored destination on a hit, zero otherwise |
| upd_valid | input | 1 | A resolved instruction is reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved instruction |
| upd_is_branch | input | 1 | The resolved instruction is a branch |
| upd_taken | input | 1 | Resolved outcome was taken |
| upd_target | input | ADDR_W | Resolved destination address |

## Verification
The hardest case to reach from the ports is a read-modify-write that has to pick up a result not yet visible in the table. This happens when updates to one entry arrive on consecutive cycles, so each one reads the table before the previous write lands. The stimulus sends taken, taken and then not-taken for the same branch on three adjacent cycles. A correct design ends with the counter at weakly taken. A design that builds each update on the stale table contents ends at weakly not taken instead. A lookup and an update to one fresh entry are also issued on the same edge, to show that the lookup sees the old contents. An update is also issued partway through the clear sweep that follows a second reset, to show that it is dropped.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_N = 2'd0;
  localparam ctr2_t CTR_WEAK_N   = 2'd1;
  localparam ctr2_t CTR_WEAK_T   = 2'd2;
  localparam ctr2_t CTR_STRONG_T = 2'd3;

  // saturating move toward the resolved outcome
  function automatic ctr2_t ctr2_step(ctr2_t c, logic taken);
    if (taken) return (c == CTR_STRONG_T) ? c : c + 2'd1;
    return (c == CTR_STRONG_N) ? c : c - 2'd1;
  endfunction

  // state of a freshly allocated entry: weak, on the side of the outcome
  function automatic ctr2_t ctr2_seed(logic taken);
    return taken ? CTR_WEAK_T : CTR_WEAK_N;
  endfunction

endpackage

// File: rtl/bpb_ram.sv
module bpb_ram #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read, read-before-write on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bpb_clear.sv
module bpb_clear #(
  parameter int ENTRIES = 4096,
  parameter int AW      = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [AW-1:0] idx
);

  localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/bpb_ctr.sv
module bpb_ctr
  import bpb_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] cur,
  input  logic          hit,
  input  logic          taken,
  output logic [CW-1:0] nxt
);

  if (CW == 1) begin : g_last
    // last-outcome scheme: state is simply the newest result
    logic unused_in;
    assign unused_in = ^{cur, hit};
    assign nxt = taken;
  end else begin : g_sat
    assign nxt = hit ? ctr2_step(cur, taken) : ctr2_seed(taken);
  end

endmodule

// File: rtl/branch_pred_buf.sv
module branch_pred_buf #(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 4096,
  parameter int PRED_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_is_branch,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);

  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_W   = ADDR_W - IDX_W - 2;
  localparam int TGT_W   = ADDR_W - 2;
  localparam int CW      = PRED_BITS;
  localparam int ENT_W   = 1 + TAG_W + TGT_W + CW;
  localparam int TGT_LSB = CW;
  localparam int TAG_LSB = CW + TGT_W;
  localparam int VLD_BIT = ENT_W - 1;

  logic unused_low;
  assign unused_low = ^{fetch_pc[1:0], upd_pc[1:0], upd_target[1:0]};

  // ---------------- clear sweep after reset ----------------
  logic             clr_busy;
  logic [IDX_W-1:0] clr_idx;

  bpb_clear #(.ENTRIES(ENTRIES), .AW(IDX_W)) u_clr (
    .clk  (clk),
    .rst  (rst),
    .busy (clr_busy),
    .idx  (clr_idx)
  );

  // ---------------- shared write port ----------------
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [ENT_W-1:0] wr_data;

  // ---------------- two table copies: lookup side and update side ----------------
  logic [IDX_W-1:0] rd_addr [2];
  logic [ENT_W-1:0] rd_data [2];

  assign rd_addr[0] = fetch_pc[IDX_W+1:2];
  assign rd_addr[1] = upd_pc[IDX_W+1:2];

  for (genvar g = 0; g < 2; g++) begin : g_copy
    bpb_ram #(.DW(ENT_W), .AW(IDX_W)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_idx),
      .wdata (wr_data),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );
  end

  // ---------------- lookup pipeline ----------------
  logic             lk_req;
  logic             lk_live;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit;
  logic [ENT_W-1:0] lk_ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_req  <= 1'b0;
      lk_live <= 1'b0;
    end else begin
      lk_req  <= fetch_valid;
      lk_live <= fetch_valid & ~clr_busy;
    end
    lk_tag <= fetch_pc[ADDR_W-1:IDX_W+2];
  end

  assign lk_ent = rd_data[0];
  assign lk_hit = lk_live & lk_ent[VLD_BIT] &
                  (lk_ent[TAG_LSB +: TAG_W] == lk_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_taken  <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_valid  <= lk_req;
      pred_hit    <= lk_hit;
      pred_taken  <= lk_hit & lk_ent[CW-1];
      pred_target <= lk_hit ? {lk_ent[TGT_LSB +: TGT_W], 2'b00} : '0;
    end
  end

  // ---------------- update read-modify-write ----------------
  logic             up_vld;
  logic [IDX_W-1:0] up_idx;
  logic [TAG_W-1:0] up_tag;
  logic             up_taken;
  logic [TGT_W-1:0] up_tgt;

  always_ff @(posedge clk) begin
    if (rst) up_vld <= 1'b0;
    else     up_vld <= upd_valid & upd_is_branch & ~clr_busy;
    up_idx   <= upd_pc[IDX_W+1:2];
    up_tag   <= upd_pc[ADDR_W-1:IDX_W+2];
    up_taken <= upd_taken;
    up_tgt   <= upd_target[ADDR_W-1:2];
  end

  // bypass of the write made one cycle earlier
  logic             bp_vld;
  logic [IDX_W-1:0] bp_idx;
  logic [ENT_W-1:0] bp_data;

  logic [ENT_W-1:0] old_ent;
  logic             old_hit;
  logic [CW-1:0]    new_ctr;
  logic [TGT_W-1:0] new_tgt;
  logic [ENT_W-1:0] new_ent;

  assign old_ent = (bp_vld && bp_idx == up_idx) ? bp_data : rd_data[1];
  assign old_hit = old_ent[VLD_BIT] & (old_ent[TAG_LSB +: TAG_W] == up_tag);

  bpb_ctr #(.CW(CW)) u_ctr (
    .cur   (old_ent[CW-1:0]),
    .hit   (old_hit),
    .taken (up_taken),
    .nxt   (new_ctr)
  );

  assign new_tgt = (!old_hit || up_taken) ? up_tgt : old_ent[TGT_LSB +: TGT_W];
  assign new_ent = {1'b1, up_tag, new_tgt, new_ctr};

  always_ff @(posedge clk) begin
    if (rst) bp_vld <= 1'b0;
    else     bp_vld <= up_vld;
    bp_idx  <= up_idx;
    bp_data <= new_ent;
  end

  assign wr_en   = clr_busy | up_vld;
  assign wr_idx  = clr_busy ? clr_idx : up_idx;
  assign wr_data = clr_busy ? '0 : new_ent;

endmodule

// File: rtl/bpb_checker.sv
module bpb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              pred_valid,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_target
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: answer arrives exactly two cycles after the lookup
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (pred_valid == $past(fetch_valid, 2)));

  // R1: no hit reported outside an answer
  p_hit_in_answer_r1: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);

  // R8: a taken prediction only comes with a hit
  p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  // R3: misses carry no prediction
  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> (pred_target == '0 && !pred_taken));

  // R11: reset clears the outputs at the next edge
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!pred_valid && !pred_hit && !pred_taken));

endmodule

bind branch_pred_buf bpb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .pred_valid  (pred_valid),
  .pred_hit    (pred_hit),
  .pred_taken  (pred_taken),
  .pred_target (pred_target)
);

// File: tb/sim_branch_pred_buf.sv
module sim_branch_pred_buf;

  localparam int ENTRIES = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_is_branch = 1'b0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  logic        v0, h0, t0, v1, h1, t1;
  logic [31:0] g0, g1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  branch_pred_buf #(.ADDR_W(32), .ENTRIES(ENTRIES), .PRED_BITS(2)) u0 (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(v0), .pred_hit(h0), .pred_taken(t0), .pred_target(g0),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_is_branch(upd_is_branch),
    .upd_taken(upd_taken), .upd_target(upd_target));

  branch_pred_buf #(.ADDR_W(32), .ENTRIES(ENTRIES), .PRED_BITS(1)) u1 (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(v1), .pred_hit(h1), .pred_taken(t1), .pred_target(g1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_is_branch(upd_is_branch),
    .upd_taken(upd_taken), .upd_target(upd_target));

  typedef struct packed {
    logic        up;   // 1: update, 0: lookup
    logic [31:0] pc;
    logic        br;
    logic        tk;
    logic [31:0] tg;   // update destination, or expected pred_target
    logic        eh;   // expected hit
    logic        e2;   // expected taken, 2-bit instance
    logic        e1;   // expected taken, 1-bit instance
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t TBL [34] = '{
    '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 empty
    '{1'b1, 32'h1000, 1'b1, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 allocate taken
    '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h2000, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 redirect
    '{1'b1, 32'h1000, 1'b1, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h1000, 1'b1, 1'b0, 32'h2000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h2000, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 hysteresis, R10
    '{1'b1, 32'h1000, 1'b1, 1'b0, 32'h2000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h2000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 32'h1000, 1'b1, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h2000, 1'b1, 1'b1, 1'b1, 4'd10}, // R10
    '{1'b1, 32'h5000, 1'b1, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 tag replace
    '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h0000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 evicted
    '{1'b0, 32'h5000, 1'b0, 1'b0, 32'h3000, 1'b1, 1'b1, 1'b1, 4'd2},
    '{1'b1, 32'h0040, 1'b0, 1'b1, 32'h9000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 non-branch
    '{1'b0, 32'h0040, 1'b0, 1'b0, 32'h0000, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, 32'h5003, 1'b0, 1'b0, 32'h3000, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 low bits
    '{1'b1, 32'h5000, 1'b1, 1'b0, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h5000, 1'b1, 1'b0, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h5000, 1'b1, 1'b0, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h5000, 1'b1, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 32'h5000, 1'b0, 1'b0, 32'h3000, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 floor
    '{1'b1, 32'h5000, 1'b1, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h5000, 1'b1, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h5000, 1'b1, 1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 32'h5000, 1'b1, 1'b0, 32'h3000, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 32'h5000, 1'b0, 1'b0, 32'h3000, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 ceiling
    '{1'b1, 32'h2008, 1'b1, 1'b0, 32'h0500, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 allocate not taken
    '{1'b0, 32'h2008, 1'b0, 1'b0, 32'h0500, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 32'h2008, 1'b1, 1'b1, 32'h0500, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 32'h2008, 1'b0, 1'b0, 32'h0500, 1'b1, 1'b1, 1'b1, 4'd5},
    '{1'b1, 32'h2008, 1'b1, 1'b1, 32'h0602, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 new dest
    '{1'b0, 32'h2008, 1'b0, 1'b0, 32'h0600, 1'b1, 1'b1, 1'b1, 4'd7},
    '{1'b1, 32'h2008, 1'b1, 1'b0, 32'h0700, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 kept
    '{1'b0, 32'h2008, 1'b0, 1'b0, 32'h0600, 1'b1, 1'b1, 1'b0, 4'd7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_upd(input logic [31:0] pc, input logic br, input logic tk,
                        input logic [31:0] tg);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_is_branch = br; upd_taken = tk; upd_target = tg;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // leaves the caller at the negedge where the answer is visible
  task automatic do_look(input logic [31:0] pc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int c0, c1;
    // R11: outputs held at zero in reset
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", {31'b0, v0}, 32'h0);
    chk("R11 hit in reset",   {31'b0, h0}, 32'h0);
    rst = 1'b0;
    repeat (ENTRIES + 4) @(negedge clk);

    // R1 / R11: cleared table, answer timing
    do_look(32'h1000);
    chk("R1 answer valid", {31'b0, v0}, 32'h1);
    chk("R11 empty after clear", {31'b0, h0}, 32'h0);
    @(negedge clk);
    chk("R1 no answer without lookup", {31'b0, v0}, 32'h0);

    // vector table
    for (int i = 0; i < 34; i++) begin
      if (TBL[i].up) begin
        do_upd(TBL[i].pc, TBL[i].br, TBL[i].tk, TBL[i].tg);
      end else begin
        do_look(TBL[i].pc);
        chk($sformatf("R%0d row %0d hit",    TBL[i].rq, i), {31'b0, h0}, {31'b0, TBL[i].eh});
        chk($sformatf("R%0d row %0d taken",  TBL[i].rq, i), {31'b0, t0}, {31'b0, TBL[i].e2});
        chk($sformatf("R%0d row %0d target", TBL[i].rq, i), g0, TBL[i].tg);
        chk($sformatf("R10 row %0d one-bit taken", i), {31'b0, t1}, {31'b0, TBL[i].e1});
      end
    end

    // R9: three updates to one entry on adjacent cycles: 2 -> 3 -> 2
    @(negedge clk);
    upd_valid = 1'b1; upd_is_branch = 1'b1; upd_pc = 32'h3000; upd_target = 32'h0800;
    upd_taken = 1'b1;
    @(negedge clk);
    upd_taken = 1'b1;
    @(negedge clk);
    upd_taken = 1'b0;
    @(negedge clk);
    upd_valid = 1'b0;
    do_look(32'h3000);
    chk("R9 back-to-back hit",   {31'b0, h0}, 32'h1);
    chk("R9 back-to-back taken", {31'b0, t0}, 32'h1);

    // R9: lookup and update to the same fresh entry in one cycle
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 32'h4000;
    upd_valid = 1'b1; upd_pc = 32'h4000; upd_is_branch = 1'b1; upd_taken = 1'b1;
    upd_target = 32'h7000;
    @(negedge clk);
    fetch_valid = 1'b0; upd_valid = 1'b0;
    @(negedge clk);
    chk("R9 same-cycle sees old", {31'b0, h0}, 32'h0);
    do_look(32'h4000);
    chk("R9 update landed", g0, 32'h7000);

    // R12: loop of 10, two passes; count correct guesses on the second
    c0 = 0;
    c1 = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int it = 0; it < 10; it++) begin
        logic act;
        act = (it != 9);
        do_look(32'h0800);
        if (pass == 1) begin
          if (t0 == act) c0++;
          if (t1 == act) c1++;
        end
        do_upd(32'h0800, 1'b1, act, 32'h0100);
      end
    end
    chk("R12 two-bit correct", c0, 32'd9);
    chk("R12 R10 one-bit correct", c1, 32'd8);

    // R11: second reset, update inside the clear window is dropped
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2000) @(negedge clk);
    do_upd(32'h5000, 1'b1, 1'b1, 32'h3000);
    repeat (ENTRIES) @(negedge clk);
    do_look(32'h5000);
    chk("R11 update in clear dropped", {31'b0, h0}, 32'h0);
    do_look(32'h2008);
    chk("R11 old entry cleared", {31'b0, h0}, 32'h0);

    report();
  end

endmodule